// File: doc/BRIEF.md
# Test Verdict and Halt Reporter

This block sits on a processor's memory-mapped bus in a simulation environment and lets a self-test program report on itself. Software writes a pointer to a short name string, and the block fetches that string from memory into a local buffer. Software later writes a status word, and the block emits one result event that carries the fetched name and a pass or fail bit. A write to a third register asks the environment to stop the run.

The register slots are write-only and word-aligned inside a 16-byte window at `BASE_ADDR` (default 0xFFFF0000). Byte offset 0x0 is the halt slot, 0x4 the verdict slot, 0x8 the name-pointer slot and 0xC a spare slot with no register. The word slot is taken from address bits [3:2] of the offset from `BASE_ADDR`. Reads are not supported. The name fetch uses a single-beat read master in which address and data complete in the same valid/ready cycle.

Top module: `test_report_unit`

## Requirements
- R1: After reset, `bus_err`, `shutdown_req`, `result_valid`, `result_fail`, `fetch_busy` and `mem_rd_valid` are 0, and all 128 bits of `result_name` are 0.
- R2: A write to offset 0x0 with any data drives `shutdown_req` high for exactly the one cycle after the write cycle.
- R3: A write of pointer P to offset 0x8 sets `fetch_busy` from the next cycle. The block then issues four reads, one per accepted `mem_rd_valid && mem_rd_ready` cycle, at P, P+4, P+8 and P+12 in that order. `fetch_busy` and `mem_rd_valid` drop in the cycle after the fourth accepted read.
- R4: Byte j (bits [8j+7:8j]) of the k-th fetched word lands in `result_name` bits [8(4k+j)+7:8(4k+j)]. Bits [127:120] always read 0.
- R5: When no fetch is busy, a write to offset 0x4 raises `result_valid` for one cycle, in the cycle after the write. `result_fail` is 1 when the written data is non-zero and 0 when it is zero, and `result_name` holds the last fetched name.
- R6: A write to offset 0x4 while `fetch_busy` is high is held back. The event comes out one cycle after `fetch_busy` falls and carries the completed name.
- R7: A new pointer write during a fetch restarts the fetch at the new pointer from its first word. The name delivered is the one at the new pointer.
- R8: A read anywhere in the window returns `bus_rdata` = 0 and raises `bus_err` for the one cycle after the access. It changes no state.
- R9: A write to offset 0xC raises `bus_err` for the one cycle after the access. It causes no halt request, no fetch and no result.
- R10: Accesses outside the 16-byte window raise no error and have no effect.
- R11: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request stays valid with an unchanged address unless a new pointer write restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe, one transfer per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| bus_err | output | 1 | One-cycle error pulse for an in-window read or a spare-slot write |
| mem_rd_valid | output | 1 | Name fetch read request |
| mem_rd_addr | output | 32 | Name fetch word address |
| mem_rd_ready | input | 1 | Memory accepts the read; data is valid in this cycle |
| mem_rd_data | input | 32 | Read data returned with ready |
| fetch_busy | output | 1 | Name fetch in progress |
| shutdown_req | output | 1 | One-cycle halt request |
| result_valid | output | 1 | One-cycle result event |
| result_fail | output | 1 | 1 = test failed, valid with the event |
| result_name | output | 128 | 16-byte name, little-endian, byte 15 zero |

## Verification
The embedded properties watch on every cycle that an error pulse follows only an in-window access, that a halt pulse follows only a halt-slot write, and that a stalled read request holds its address. They also check that the name's terminator byte stays zero and that no result leaves while a fetch was running the cycle before. Only the bench scenarios show that whole names arrive in the right byte order and that a verdict written during a stalled fetch is delivered late with the finished name. The scenarios also cover a restarted fetch yielding the second string and out-of-window traffic leaving everything untouched.

// File: rtl/trep_pkg.sv
package trep_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned ADDR_BITS  = 32;
    localparam int unsigned NAME_LEN   = 16;
    localparam int unsigned WIN_SLOTS  = 4;
    localparam int unsigned SLOT_LSB   = 2;
    localparam int unsigned SLOT_BITS  = $clog2(WIN_SLOTS);

    // Word slots inside the window; the spare slot decodes to an error
    typedef enum logic [SLOT_BITS-1:0] {
        SLOT_HALT    = 2'd0,
        SLOT_VERDICT = 2'd1,
        SLOT_NAMEPTR = 2'd2,
        SLOT_SPARE   = 2'd3
    } slot_e;

    // One-hot write decode carried from the decoder to the datapath
    typedef struct packed {
        logic halt;
        logic verdict;
        logic nameptr;
        logic spare;
    } wr_hits_t;

    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_RUN  = 1'b1
    } fetch_state_e;

    function automatic logic [WORD_W-1:0] keep_mask(input bit last_word, input int unsigned dw);
        logic [WORD_W-1:0] m;
        m = '1;
        if (last_word) m[dw-1 -: 8] = 8'h00;
        return m;
    endfunction

endpackage

// File: rtl/trep_decode.sv
module trep_decode
    import trep_pkg::*;
#(
    parameter int unsigned ADDR_W    = ADDR_BITS,
    parameter int unsigned DATA_W    = WORD_W,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wr_hits_t          hits,
    output logic              bus_err,
    output logic              shutdown_req,
    output logic [ADDR_W-1:0] nameptr_q
);

    localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(WIN_SLOTS * 4);

    logic [ADDR_W-1:0] offset;
    logic              in_win;
    slot_e             slot;
    logic              wr_in;
    logic              rd_in;

    always_comb begin
        offset = bus_addr - BASE_ADDR;
        in_win = offset < WIN_BYTES;
        slot   = slot_e'(offset[SLOT_LSB +: SLOT_BITS]);
        wr_in  = bus_req && bus_we && in_win;
        rd_in  = bus_req && !bus_we && in_win;
        hits.halt    = wr_in && (slot == SLOT_HALT);
        hits.verdict = wr_in && (slot == SLOT_VERDICT);
        hits.nameptr = wr_in && (slot == SLOT_NAMEPTR);
        hits.spare   = wr_in && (slot == SLOT_SPARE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_err      <= 1'b0;
            shutdown_req <= 1'b0;
            nameptr_q    <= '0;
        end else begin
            bus_err      <= rd_in || hits.spare;
            shutdown_req <= hits.halt;
            if (hits.nameptr) nameptr_q <= ADDR_W'(bus_wdata);
        end
    end

    // R8, R9: an error pulse only follows an access that landed in the window
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_req && ((bus_addr - BASE_ADDR) < WIN_BYTES)));

    // R2: a halt pulse only follows a write to the first word of the window
    assert_halt_cause_R2: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(bus_req && bus_we && ((bus_addr >> 2) == (BASE_ADDR >> 2))));

endmodule

// File: rtl/trep_name_fetch.sv
module trep_name_fetch
    import trep_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_BITS,
    parameter int unsigned DATA_W     = WORD_W,
    parameter int unsigned NAME_BYTES = NAME_LEN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       base_ptr,
    output logic                    mem_rd_valid,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_ready,
    input  logic [DATA_W-1:0]       mem_rd_data,
    output logic                    busy,
    output logic [NAME_BYTES*8-1:0] name_q
);

    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam int unsigned NAME_WORDS = NAME_BYTES / WORD_BYTES;
    localparam int unsigned CNT_W      = (NAME_WORDS > 1) ? $clog2(NAME_WORDS) : 1;
    localparam int unsigned BYTE_SH    = $clog2(WORD_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NAME_WORDS - 1);

    fetch_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign busy         = (state_q == FETCH_RUN);
    assign mem_rd_valid = busy;
    assign mem_rd_addr  = base_ptr + (ADDR_W'(cnt_q) << BYTE_SH);
    assign take         = busy && mem_rd_ready && !start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FETCH_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            state_q <= FETCH_RUN;
            cnt_q   <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) state_q <= FETCH_IDLE;
        end
    end

    for (genvar w = 0; w < NAME_WORDS; w++) begin : g_word
        localparam logic [DATA_W-1:0] KEEP = DATA_W'(keep_mask(w == NAME_WORDS - 1, DATA_W));
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (take && (cnt_q == CNT_W'(w))) begin
                word_q <= mem_rd_data & KEEP;
            end
        end
        assign name_q[w*DATA_W +: DATA_W] = word_q;
    end

    // R11: a stalled request keeps its address until accepted or restarted
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready && !start) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R4: the terminator byte of the name never carries fetched data
    assert_term_byte_R4: assert property (@(posedge clk) disable iff (rst)
        name_q[NAME_BYTES*8-1 -: 8] == 8'h00);

    // R3: the fetch only ends after an accepted read
    assert_end_on_accept_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mem_rd_valid && mem_rd_ready));

endmodule

// File: rtl/trep_result_gate.sv
module trep_result_gate (
    input  logic clk,
    input  logic rst,
    input  logic verdict_hit,
    input  logic verdict_fail,
    input  logic busy,
    output logic result_valid,
    output logic result_fail
);

    logic pend_q;
    logic pend_fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            pend_fail_q  <= 1'b0;
            result_valid <= 1'b0;
            result_fail  <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (verdict_hit) begin
                if (!busy) begin
                    result_valid <= 1'b1;
                    result_fail  <= verdict_fail;
                    pend_q       <= 1'b0;
                end else begin
                    pend_q       <= 1'b1;
                    pend_fail_q  <= verdict_fail;
                end
            end else if (pend_q && !busy) begin
                result_valid <= 1'b1;
                result_fail  <= pend_fail_q;
                pend_q       <= 1'b0;
            end
        end
    end

    // R6: no event leaves while the fetch was running in the previous cycle
    assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(!busy));

    // R5: an event only follows a verdict write or a held verdict
    assert_event_cause_R5: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(verdict_hit || pend_q));

endmodule

// File: rtl/test_report_unit.sv
module test_report_unit
    import trep_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_BITS,
    parameter int unsigned DATA_W     = WORD_W,
    parameter int unsigned NAME_BYTES = NAME_LEN,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_err,
    output logic                    mem_rd_valid,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic                    mem_rd_ready,
    input  logic [DATA_W-1:0]       mem_rd_data,
    output logic                    fetch_busy,
    output logic                    shutdown_req,
    output logic                    result_valid,
    output logic                    result_fail,
    output logic [NAME_BYTES*8-1:0] result_name
);

    wr_hits_t          hits;
    logic [ADDR_W-1:0] nameptr_q;

    assign bus_rdata = '0;

    trep_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .clk          (clk),
        .rst          (rst),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .hits         (hits),
        .bus_err      (bus_err),
        .shutdown_req (shutdown_req),
        .nameptr_q    (nameptr_q)
    );

    trep_name_fetch #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NAME_BYTES (NAME_BYTES)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .start        (hits.nameptr),
        .base_ptr     (nameptr_q),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .busy         (fetch_busy),
        .name_q       (result_name)
    );

    trep_result_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .verdict_hit  (hits.verdict),
        .verdict_fail (|bus_wdata),
        .busy         (fetch_busy),
        .result_valid (result_valid),
        .result_fail  (result_fail)
    );

endmodule

// File: tb/test_report_unit_bench.sv
`timescale 1ns/1ps
module test_report_unit_bench;

    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic         mem_rd_valid;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_ready;
    logic [31:0]  mem_rd_data;
    logic         fetch_busy;
    logic         shutdown_req;
    logic         result_valid;
    logic         result_fail;
    logic [127:0] result_name;

    always #2.5 clk = ~clk;

    test_report_unit u_test_report_unit (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .fetch_busy(fetch_busy), .shutdown_req(shutdown_req),
        .result_valid(result_valid), .result_fail(result_fail),
        .result_name(result_name)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Memory model: every byte of a word depends on the address, top byte never zero
    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[7:0] | 8'h40, a[15:8] ^ 8'h3C, ~a[7:0], a[7:0] + 8'h21};
    endfunction

    function automatic logic [127:0] name_of(input logic [31:0] p);
        logic [127:0] n;
        for (int k = 0; k < 4; k++) n[32*k +: 32] = memword(p + 32'(4*k));
        n[127:120] = 8'h00;
        return n;
    endfunction

    int tick = 0;
    bit stall_en = 0;
    always @(posedge clk) tick <= tick + 1;
    assign mem_rd_ready = !stall_en || (tick % 3 == 0);
    assign mem_rd_data  = memword(mem_rd_addr);

    typedef struct { bit fail; logic [127:0] name; } exp_t;
    exp_t exp_q[$];
    logic [127:0] cur_name = '0;

    // Monitor: read-address order, result scoreboard, pulse counters
    logic [31:0] exp_ptr = '0;
    int exp_k = 0;
    bit prev_busy = 0;
    int sd_cnt = 0;
    int err_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (shutdown_req) sd_cnt++;
            if (bus_err) err_cnt++;
            if (bus_req && bus_we && bus_addr == BASE + 32'h8) begin
                exp_ptr = bus_wdata;
                exp_k = 0;
            end else if (mem_rd_valid && mem_rd_ready) begin
                check(mem_rd_addr == exp_ptr + 32'(4*exp_k), "R3", "read address order",
                      mem_rd_addr, exp_ptr + 32'(4*exp_k));
                check(exp_k < 4, "R3", "read count", exp_k, 3);
                exp_k++;
            end
            if (result_valid) begin
                check(!prev_busy, "R6", "event while fetch busy", prev_busy, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected result event", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(result_name == e.name, "R4", "result name", result_name, e.name);
                    check(result_fail == e.fail, "R5", "result fail bit", result_fail, e.fail);
                end
            end
            prev_busy = fetch_busy;
        end
    end

    task automatic bus_xfer(input bit we, input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic write_ptr(input logic [31:0] p);
        cur_name = name_of(p);
        bus_xfer(1'b1, BASE + 32'h8, p);
    endtask

    task automatic write_verdict(input logic [31:0] v);
        exp_t e;
        e.fail = (v != 0);
        e.name = cur_name;
        exp_q.push_back(e);
        bus_xfer(1'b1, BASE + 32'h4, v);
    endtask

    task automatic wait_idle();
        while (fetch_busy) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual %0d cycles expected completion", 100000);
            report();
            $finish;
        end
    end

    initial begin
        int s0;
        int e0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1: reset state
        check(!bus_err && !shutdown_req && !result_valid && !result_fail, "R1",
              "control outputs after reset",
              {bus_err, shutdown_req, result_valid, result_fail}, 0);
        check(!fetch_busy && !mem_rd_valid, "R1", "fetch idle after reset",
              {fetch_busy, mem_rd_valid}, 0);
        check(result_name == '0, "R1", "name cleared", result_name, 0);

        // R2: halt pulse for zero and non-zero data
        bus_xfer(1'b1, BASE, 32'h0);
        check(shutdown_req == 1'b1, "R2", "halt pulse high", shutdown_req, 1);
        @(posedge clk); #1;
        check(shutdown_req == 1'b0, "R2", "halt pulse one cycle", shutdown_req, 0);
        bus_xfer(1'b1, BASE + 32'h2, 32'hDEAD_BEEF);
        check(shutdown_req == 1'b1, "R2", "halt pulse nonzero data", shutdown_req, 1);
        @(posedge clk); #1;
        check(shutdown_req == 1'b0, "R2", "halt pulse ends", shutdown_req, 0);

        // R5: verdict with no name fetched, pass
        write_verdict(32'h0);
        check(result_valid == 1'b1, "R5", "event in cycle after write", result_valid, 1);
        @(posedge clk); #1;
        check(result_valid == 1'b0, "R5", "event one cycle", result_valid, 0);

        // R3, R4: fetch without stalls, then fail verdict
        write_ptr(32'h0000_1000);
        check(fetch_busy == 1'b1, "R3", "busy after pointer write", fetch_busy, 1);
        wait_idle();
        check(result_name == name_of(32'h0000_1000), "R4", "name buffer after fetch",
              result_name, name_of(32'h0000_1000));
        write_verdict(32'h0000_0005);
        repeat (3) @(posedge clk);

        // R6: verdict during a stalled fetch is held back
        stall_en = 1;
        write_ptr(32'h0002_34A8);
        write_verdict(32'h0);
        check(fetch_busy == 1'b1, "R6", "fetch still busy after verdict", fetch_busy, 1);
        check(result_valid == 1'b0, "R6", "no early event", result_valid, 0);
        wait_idle();
        check(exp_q.size() == 0, "R6", "held event delivered", exp_q.size(), 0);

        // R7: restart a running fetch with a new pointer
        write_ptr(32'h0000_5550);
        repeat (2) @(posedge clk);
        write_ptr(32'h0000_7F3C);
        wait_idle();
        stall_en = 0;
        write_verdict(32'h0000_0007);
        repeat (3) @(posedge clk); #1;
        check(exp_q.size() == 0, "R7", "restarted fetch result", exp_q.size(), 0);

        // R8: read in window
        e0 = err_cnt; s0 = sd_cnt;
        bus_xfer(1'b0, BASE + 32'h4, 32'h0);
        check(bus_err == 1'b1, "R8", "read error pulse", bus_err, 1);
        check(bus_rdata == 32'h0, "R8", "read data zero", bus_rdata, 0);
        @(posedge clk); #1;
        check(bus_err == 1'b0 && err_cnt == e0 + 1, "R8", "read error one cycle", err_cnt - e0, 1);

        // R9: spare slot write
        e0 = err_cnt;
        bus_xfer(1'b1, BASE + 32'hC, 32'h1234_5678);
        check(bus_err == 1'b1, "R9", "spare write error", bus_err, 1);
        check(!fetch_busy && !shutdown_req, "R9", "spare write no effect",
              {fetch_busy, shutdown_req}, 0);
        repeat (3) @(posedge clk); #1;
        check(err_cnt == e0 + 1, "R9", "spare error one cycle", err_cnt - e0, 1);
        check(sd_cnt == s0, "R9", "no halt from spare or read", sd_cnt - s0, 0);

        // R10: outside the window
        e0 = err_cnt;
        bus_xfer(1'b1, BASE + 32'h10, 32'h0000_2000);
        bus_xfer(1'b1, BASE - 32'h4, 32'h1);
        bus_xfer(1'b0, BASE + 32'h20, 32'h0);
        bus_xfer(1'b1, BASE + 32'h18, 32'h0);
        repeat (4) @(posedge clk); #1;
        check(err_cnt == e0, "R10", "no error outside window", err_cnt - e0, 0);
        check(sd_cnt == s0 && !fetch_busy, "R10", "no halt or fetch outside window",
              {sd_cnt - s0, 31'(fetch_busy)}, 0);
        check(result_name == name_of(32'h0000_7F3C), "R10", "name unchanged",
              result_name, name_of(32'h0000_7F3C));
        check(exp_q.size() == 0, "R5", "no events outstanding", exp_q.size(), 0);

        done = 1;
        report();
        $finish;
    end

endmodule